// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This unit compares two IEEE-754 operands of one format, single (32-bit) or double (64-bit), and returns the outcome as a mask that fills the operand width. A 5-bit condition code selects one of 22 predicates. Each predicate tests some mix of four relations between the operands: unordered, equal, less-than and greater-than. Every predicate has a quiet form and a signaling form. The two forms give the same mask and differ only in which NaN inputs raise the invalid-operation flag.

A compare is launched by a one-cycle start strobe with the format, code and operands. One cycle later the unit presents the mask with a valid pulse. If the code is not a compare, it raises an illegal-code pulse instead. The invalid flag is sticky. It stays set until a synchronous reset or the clear input, so several compares can be checked together after they run.

Top module: `fpPredCmp`

## Requirements
- R1: Codes 0 to 7 are quiet predicates. Bit 0 adds "unordered" to the test. Bits 2:1 pick the relation: 00 none (always false), 01 equal, 10 less-than, 11 less-or-equal. So code 0 is always false, 1 is unordered, 2 equal, 3 unordered-or-equal, 4 less-than, 5 unordered-or-less, 6 less-or-equal and 7 unordered-or-less-or-equal.
- R2: Codes 8 to 15 give the same masks as codes 0 to 7. Bit 3 set marks them as signaling.
- R3: Code 17 is ordered (neither operand NaN). Code 18 is unordered-or-not-equal. Code 19 is not-equal and is false when either operand is NaN. Codes 25, 26 and 27 give the same masks as 17, 18 and 19 and are signaling.
- R4: A true predicate gives all 64 mask bits set for double, or bits 31:0 set and bits 63:32 clear for single. A false predicate gives a zero mask.
- R5: The mask and a one-cycle valid pulse appear on the clock edge after the edge that samples the start strobe.
- R6: Codes 16, 20 to 24 and 28 to 31 give a one-cycle illegal pulse at the same latency, with no valid pulse and a zero mask, and leave the invalid flag unchanged.
- R7: A NaN has an all-ones exponent and a nonzero fraction. A signaling NaN is a NaN whose fraction MSB is 0. A quiet predicate raises invalid only when an operand is a signaling NaN.
- R8: A signaling predicate raises invalid when either operand is any NaN.
- R9: The always-false codes 0 and 8 give a zero mask but still raise invalid under R7 and R8.
- R10: +0 and -0 compare equal. Negative values are ordered by reversed magnitude, so -2 < -1 < +1.
- R11: Invalid stays set until reset or the clear input. A compare that raises invalid in the same cycle as a clear leaves it set.
- R12: After reset the mask, valid, illegal and invalid outputs are all zero.
- R13: In single format only bits 31:0 of each operand are used. Bits 63:32 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Launch a compare this cycle |
| dblIn | input | 1 | 1 = double format, 0 = single format |
| condIn | input | 5 | Predicate condition code |
| opA | input | 64 | First operand (single in bits 31:0) |
| opB | input | 64 | Second operand (single in bits 31:0) |
| clrInvalid | input | 1 | Clear the sticky invalid flag |
| maskOut | output | 64 | All-ones or all-zeros predicate mask |
| validOut | output | 1 | Mask valid pulse |
| invalidOut | output | 1 | Sticky invalid-operation flag |
| illegalOut | output | 1 | Undefined condition code pulse |

## Verification
A wrong decode of the condition code shows up in the mask on the cycle after the start strobe, but only for operand pairs where the chosen relation differs from the intended one. For that reason every code is run against ordered, equal, signed-zero and NaN pairs. A bad key mapping for negative numbers or for zeros shows up only with negative or zero operands. A fault in the NaN classification shows up only in the sticky invalid flag. That flag then stays wrong until the next clear, so the flag is checked after every compare and cleared before each code is tried.

// File: rtl/fpPredCmpPkg.sv
package fpPredCmpPkg;
  localparam int COND_W = 5;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic fire;       // legal compare launched
    logic reject;     // start with an undefined code
    logic dbl;        // double format
    logic signaling;  // any NaN raises invalid
    logic takeUn;     // unordered satisfies the predicate
    logic takeEq;     // equal satisfies the predicate
    logic takeLt;     // a < b satisfies the predicate
    logic takeGt;     // a > b satisfies the predicate
  } cmpStrobes_t;
endpackage

// File: rtl/fpPredCmpClass.sv
module fpPredCmpClass #(
  parameter int W  = 32,
  parameter int EW = 8,
  parameter int KW = 64
) (
  input  logic [W-1:0]  val,
  output logic          isNan,
  output logic          isSnan,
  output logic          isZero,
  output logic [KW-1:0] key
);
  localparam int FW = W - EW - 1;

  logic [EW-1:0] expField;
  logic [FW-1:0] fracField;
  logic [W-1:0]  keyNarrow;

  assign expField  = val[W-2 -: EW];
  assign fracField = val[FW-1:0];
  assign isNan     = (&expField) && (|fracField);
  assign isSnan    = isNan && !fracField[FW-1];
  assign isZero    = ~|val[W-2:0];

  // Map sign-magnitude to an unsigned key that follows numeric order.
  assign keyNarrow = val[W-1] ? ~val : {1'b1, val[W-2:0]};
  assign key       = KW'(keyNarrow);
endmodule

// File: rtl/fpPredCmpCtrl.sv
module fpPredCmpCtrl
  import fpPredCmpPkg::*;
(
  input  logic              startIn,
  input  logic              dblIn,
  input  logic [COND_W-1:0] condIn,
  output cmpStrobes_t       strb
);
  logic extended;
  logic legal;

  assign extended = condIn[4];
  // Low block (0-15) is fully populated; high block holds x01, x10, x11.
  assign legal = !extended || (!condIn[2] && (condIn[1:0] != 2'b00));

  always_comb begin
    strb           = '0;
    strb.fire      = startIn && legal;
    strb.reject    = startIn && !legal;
    strb.dbl       = dblIn;
    strb.signaling = condIn[3];
    if (extended) begin
      strb.takeUn = condIn[1] && !condIn[0];
      strb.takeEq = (condIn[1:0] == 2'b01);
      strb.takeLt = 1'b1;
      strb.takeGt = 1'b1;
    end else begin
      strb.takeUn = condIn[0];
      strb.takeEq = condIn[1];
      strb.takeLt = condIn[2];
      strb.takeGt = 1'b0;
    end
  end
endmodule

// File: rtl/fpPredCmpDp.sv
module fpPredCmpDp
  import fpPredCmpPkg::*;
#(
  parameter int DW  = 64,
  parameter int DEW = 11,
  parameter int SW  = 32,
  parameter int SEW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cmpStrobes_t   strb,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic          clrInvalid,
  output logic [DW-1:0] maskOut,
  output logic          validOut,
  output logic          invalidOut,
  output logic          illegalOut
);
  localparam logic [DW-1:0] SINGLE_MASK = DW'({SW{1'b1}});

  logic [1:0]    sNan, sSnan, sZero, dNan, dSnan, dZero;
  logic [DW-1:0] sKey [2];
  logic [DW-1:0] dKey [2];

  for (genvar op = 0; op < 2; op++) begin : g_opnd
    logic [DW-1:0] raw;
    assign raw = (op == 0) ? opA : opB;

    fpPredCmpClass #(.W(SW), .EW(SEW), .KW(DW)) u_sgl (
      .val(raw[SW-1:0]), .isNan(sNan[op]), .isSnan(sSnan[op]),
      .isZero(sZero[op]), .key(sKey[op]));

    fpPredCmpClass #(.W(DW), .EW(DEW), .KW(DW)) u_dbl (
      .val(raw), .isNan(dNan[op]), .isSnan(dSnan[op]),
      .isZero(dZero[op]), .key(dKey[op]));
  end

  logic [1:0]    nanSel, snanSel, zeroSel;
  logic [DW-1:0] keyA, keyB;
  logic          unord, bothZero, relEq, relLt, relGt, holds, invalidNow;
  logic [DW-1:0] fullMask;

  always_comb begin
    nanSel     = strb.dbl ? dNan    : sNan;
    snanSel    = strb.dbl ? dSnan   : sSnan;
    zeroSel    = strb.dbl ? dZero   : sZero;
    keyA       = strb.dbl ? dKey[0] : sKey[0];
    keyB       = strb.dbl ? dKey[1] : sKey[1];
    fullMask   = strb.dbl ? '1      : SINGLE_MASK;

    unord      = |nanSel;
    bothZero   = &zeroSel;
    relEq      = !unord && (bothZero || (keyA == keyB));
    relLt      = !unord && !bothZero && (keyA < keyB);
    relGt      = !unord && !bothZero && (keyA > keyB);

    holds      = (strb.takeUn && unord) || (strb.takeEq && relEq) ||
                 (strb.takeLt && relLt) || (strb.takeGt && relGt);
    invalidNow = strb.signaling ? unord : (|snanSel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskOut    <= '0;
      validOut   <= 1'b0;
      illegalOut <= 1'b0;
      invalidOut <= 1'b0;
    end else begin
      validOut   <= strb.fire;
      illegalOut <= strb.reject;
      maskOut    <= (strb.fire && holds) ? fullMask : '0;
      invalidOut <= (strb.fire && invalidNow) || (invalidOut && !clrInvalid);
    end
  end
endmodule

// File: rtl/fpPredCmp.sv
module fpPredCmp
  import fpPredCmpPkg::*;
#(
  parameter int DW  = 64,
  parameter int DEW = 11,
  parameter int SW  = 32,
  parameter int SEW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic              dblIn,
  input  logic [COND_W-1:0] condIn,
  input  logic [DW-1:0]     opA,
  input  logic [DW-1:0]     opB,
  input  logic              clrInvalid,
  output logic [DW-1:0]     maskOut,
  output logic              validOut,
  output logic              invalidOut,
  output logic              illegalOut
);
  cmpStrobes_t strb;

  fpPredCmpCtrl u_ctrl (
    .startIn(startIn), .dblIn(dblIn), .condIn(condIn), .strb(strb));

  fpPredCmpDp #(.DW(DW), .DEW(DEW), .SW(SW), .SEW(SEW)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .opA(opA), .opB(opB),
    .clrInvalid(clrInvalid), .maskOut(maskOut), .validOut(validOut),
    .invalidOut(invalidOut), .illegalOut(illegalOut));
endmodule

// File: rtl/fpPredCmpChk.sv
module fpPredCmpChk #(
  parameter int DW = 64,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          startIn,
  input logic          dblIn,
  input logic          clrInvalid,
  input logic [DW-1:0] maskOut,
  input logic          validOut,
  input logic          invalidOut,
  input logic          illegalOut
);
  localparam logic [DW-1:0] LOW_ONES = DW'({SW{1'b1}});

  // R6
  valid_illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(validOut && illegalOut));

  // R4
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (maskOut == '0 || maskOut == '1 || maskOut == LOW_ONES));

  // R4
  single_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (validOut && !$past(dblIn)) |-> (maskOut[DW-1:SW] == '0));

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(startIn));

  // R6
  illegal_latency_chk: assert property (@(posedge clk) disable iff (rst)
    illegalOut |-> ($past(startIn) && maskOut == '0));

  // R5
  mask_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (maskOut != '0) |-> validOut);

  // R11
  invalid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(invalidOut) && !$past(clrInvalid)) |-> invalidOut);

  // R11
  invalid_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(invalidOut) |-> validOut);
endmodule

bind fpPredCmp fpPredCmpChk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .startIn(startIn), .dblIn(dblIn),
  .clrInvalid(clrInvalid), .maskOut(maskOut), .validOut(validOut),
  .invalidOut(invalidOut), .illegalOut(illegalOut));

// File: tb/test_fpPredCmp.sv
`timescale 1ns/1ps
module test_fpPredCmp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startIn = 1'b0, dblIn = 1'b0, clrInvalid = 1'b0;
  logic [4:0]  condIn = '0;
  logic [63:0] opA = '0, opB = '0;
  logic [63:0] maskOut;
  logic        validOut, invalidOut, illegalOut;

  int total = 0;
  int fails = 0;
  bit expInv = 1'b0;

  typedef struct {
    logic [63:0] mask;
    bit          valid;
    bit          illegal;
    bit          inv;
    int          code;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  fpPredCmp i_fpPredCmp (
    .clk(clk), .rst(rst), .startIn(startIn), .dblIn(dblIn), .condIn(condIn),
    .opA(opA), .opB(opB), .clrInvalid(clrInvalid), .maskOut(maskOut),
    .validOut(validOut), .invalidOut(invalidOut), .illegalOut(illegalOut));

  localparam logic [63:0] D_P1 = 64'h3FF0000000000000, D_P2 = 64'h4000000000000000;
  localparam logic [63:0] D_M1 = 64'hBFF0000000000000, D_M2 = 64'hC000000000000000;
  localparam logic [63:0] D_PZ = 64'h0, D_MZ = 64'h8000000000000000;
  localparam logic [63:0] D_QN = 64'h7FF8000000000000, D_SN = 64'h7FF0000000000001;
  localparam logic [31:0] S_P1 = 32'h3F800000, S_P2 = 32'h40000000, S_M2 = 32'hC0000000;
  localparam logic [31:0] S_MZ = 32'h80000000, S_QN = 32'h7FC00000, S_SN = 32'h7F800001;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isNanV(input bit dbl, input logic [63:0] v);
    if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic bit isSnanV(input bit dbl, input logic [63:0] v);
    if (dbl) return isNanV(1'b1, v) && !v[51];
    return isNanV(1'b0, v) && !v[22];
  endfunction

  function automatic real toReal(input bit dbl, input logic [63:0] v);
    logic [10:0] e;
    if (dbl) return $bitstoreal(v);
    if (v[30:23] == 0) return 0.0;
    e = 11'(v[30:23]) - 11'd127 + 11'd1023;
    return $bitstoreal({v[31], e, v[22:0], 29'b0});
  endfunction

  task automatic issue(input bit dbl, input int code, input logic [63:0] a,
                       input logic [63:0] b, input bit clr, input string tag);
    item_t it;
    bit un, eq, lt, gt, hold, legal, sig, invNow;
    real ra, rb;
    un = isNanV(dbl, a) || isNanV(dbl, b);
    ra = toReal(dbl, a);
    rb = toReal(dbl, b);
    eq = !un && (ra == rb);
    lt = !un && (ra < rb);
    gt = !un && (ra > rb);
    legal = 1'b1;
    case (code)
      0, 8:   hold = 1'b0;
      1, 9:   hold = un;
      2, 10:  hold = eq;
      3, 11:  hold = un || eq;
      4, 12:  hold = lt;
      5, 13:  hold = un || lt;
      6, 14:  hold = lt || eq;
      7, 15:  hold = un || lt || eq;
      17, 25: hold = !un;
      18, 26: hold = un || lt || gt;
      19, 27: hold = lt || gt;
      default: begin hold = 1'b0; legal = 1'b0; end
    endcase
    sig = (code >= 8 && code <= 15) || (code >= 25 && code <= 27);
    invNow = sig ? un : (isSnanV(dbl, a) || isSnanV(dbl, b));
    expInv = (legal && invNow) || (expInv && !clr);
    it.mask = (legal && hold) ? (dbl ? 64'hFFFFFFFFFFFFFFFF : 64'h00000000FFFFFFFF) : 64'h0;
    it.valid = legal;
    it.illegal = !legal;
    it.inv = expInv;
    it.code = code;
    it.tag = tag;
    @(negedge clk);
    startIn = 1'b1; dblIn = dbl; condIn = 5'(code);
    opA = a; opB = b; clrInvalid = clr;
    sb.push_back(it);
  endtask

  task automatic clearOnly();
    @(negedge clk);
    startIn = 1'b0; clrInvalid = 1'b1;
    expInv = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    startIn = 1'b0; clrInvalid = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor: one expected item per start strobe, compared one edge later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        string mt, vt;
        it = sb.pop_front();
        mt = (it.code < 8) ? "R1" : (it.code < 16) ? "R2" : "R3";
        vt = (it.code == 0 || it.code == 8) ? "R9" :
             ((it.code >= 8 && it.code <= 15) || it.code >= 25) ? "R8" : "R7";
        check(maskOut == it.mask,
              $sformatf("%s/R4 %s mask code=%0d", mt, it.tag, it.code), maskOut, it.mask);
        check(validOut == it.valid,
              $sformatf("R5 %s valid code=%0d", it.tag, it.code), 64'(validOut), 64'(it.valid));
        check(illegalOut == it.illegal,
              $sformatf("R6 %s illegal code=%0d", it.tag, it.code), 64'(illegalOut), 64'(it.illegal));
        check(invalidOut == it.inv,
              $sformatf("%s/R11 %s invalid code=%0d", vt, it.tag, it.code), 64'(invalidOut), 64'(it.inv));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  logic [63:0] pa [9] = '{D_P1, D_P2, D_P1, D_M2, D_M1, D_PZ, D_QN, D_P1, D_M2};
  logic [63:0] pb [9] = '{D_P2, D_P1, D_P1, D_M1, D_M2, D_MZ, D_P1, D_SN, D_P1};
  logic [31:0] qa [6] = '{S_P1, S_M2, S_QN, S_SN, S_MZ, S_P2};
  logic [31:0] qb [6] = '{S_P2, S_P1, S_P1, S_P1, 32'h0, S_P2};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(maskOut == 0, "R12 reset mask", maskOut, 64'h0);
    check(validOut == 0, "R12 reset valid", 64'(validOut), 64'h0);
    check(illegalOut == 0, "R12 reset illegal", 64'(illegalOut), 64'h0);
    check(invalidOut == 0, "R12 reset invalid", 64'(invalidOut), 64'h0);

    // double format: every code against ordered, signed-zero and NaN pairs (R10)
    for (int code = 0; code < 32; code++) begin
      clearOnly();
      for (int p = 0; p < 9; p++) issue(1'b1, code, pa[p], pb[p], 1'b0, "R10 dbl");
    end
    idle();

    // single format with junk in bits 63:32 (R13)
    for (int code = 0; code < 32; code++) begin
      clearOnly();
      for (int p = 0; p < 6; p++)
        issue(1'b0, code, {32'hDEADBEEF, qa[p]}, {32'h5A5A0F0F, qb[p]}, 1'b0, "R13 sgl");
    end
    idle();

    // R11: set wins over a clear in the same cycle, then a clear alone drops it
    issue(1'b1, 1, D_SN, D_P1, 1'b1, "R11 set+clear");
    idle();
    clearOnly();
    issue(1'b1, 2, D_P1, D_P1, 1'b0, "R11 after clear");
    // R6: illegal code leaves a raised flag untouched
    issue(1'b1, 9, D_QN, D_P1, 1'b0, "R11 raise");
    issue(1'b1, 20, D_QN, D_SN, 1'b0, "R6 keep");
    issue(1'b1, 16, D_P1, D_P1, 1'b1, "R6 clear");
    idle();
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule